// File: doc/BRIEF.md
# Protected Control and Fault Register Unit

This block sits behind a byte-level two-wire slave front end. The front end decodes the bus and hands this unit one pulse per event: a start condition, a stop condition, a received slave byte, a word address byte, or a complete data byte with its acknowledge slot. For each byte the unit returns an acknowledge decision one cycle later. It also presents the read data of the register that the last matched slave byte selected.

The unit holds two registers. The first is a configuration register whose nonvolatile fields are the power-up delay code, the watchdog period code and a block-protect bit. A change to those fields must follow a three-step unlock. After a committed nonvolatile change, the unit models the storage write time as a busy window that lasts a set number of clock cycles. The second is a fault register. Software arms its flags by writing ones to them. Hardware clears a flag to zero when the matching supply, watchdog or manual-reset event occurs.

Writes take effect only at the stop condition, and only after exactly one accepted data byte. The unit reads neither the bit-level bus nor any analogue threshold logic.

Top module: `supv_reg_unit`

## Requirements
- R1: A slave byte is acknowledged only when bits 7..4 are 1011, bit 3 equals the DEV_SEL parameter, bit 2 is 0, and the unit is not busy. In that byte, bit 1 selects the register (1 = configuration, 0 = fault) and bit 0 is read (1) or write (0). Any other slave byte is not acknowledged, and the bytes that follow it are not acknowledged either.
- R2: After reset, the configuration register reads 61h and the fault register reads 00h. The configuration register's bit positions are: bit7 delay code high, bit6 watchdog code high, bit5 watchdog code low, bit4 block protect, bit3 zero, bit2 register-unlock latch, bit1 write-enable latch, bit0 delay code low. At reset the delay code is 01, the watchdog code is 11, block protect is 0 and both latches are 0. The busy output is low.
- R3: Writing 02h to the configuration register (when both latches are not set) sets the write-enable latch and clears the register-unlock latch. It starts no busy window.
- R4: Writing 06h while the write-enable latch is set also sets the register-unlock latch. The register-unlock latch is never set while the write-enable latch is clear.
- R5: With both latches set, a data byte whose bits 3..1 are 001 loads the nonvolatile fields from bits 7, 6, 5, 4 and 0. It clears the register-unlock latch and holds busy high for NV_CYCLES cycles. The nonvolatile fields change at no other time.
- R6: With both latches set, a data byte whose bits 3..1 are 011 leaves the nonvolatile fields unchanged and keeps the register-unlock latch set.
- R7: While the write-enable latch is clear, any configuration data byte other than 02h is not acknowledged and changes nothing. While the write-protect input is high, no data byte to either register is acknowledged and nothing changes.
- R8: A second data byte in the same write is not acknowledged, and the whole write is abandoned at the stop condition.
- R9: A stop condition that arrives before a complete data byte changes nothing. A word address other than REG_ADDR leaves the data byte unacknowledged and changes nothing.
- R10: While busy is high, a matching slave byte is not acknowledged.
- R11: Fault register bits 7..3 are the supply-1-low, supply-2-low, supply-3-low, watchdog and manual-reset flags, and bits 2..0 read 0. An active event input forces its flag to 0 on the next clock, and this takes priority over a write. A write to the fault register sets the flags from the data byte and does not need the write-enable latch.
- R12: The read data output shows the register selected by bit 1 of the last acknowledged slave byte. It shows the configuration register after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start condition pulse |
| txn_stop | input | 1 | Stop condition pulse |
| slave_vld | input | 1 | Slave byte received pulse |
| slave_byte | input | 8 | Slave byte value |
| addr_vld | input | 1 | Word address byte received pulse |
| addr_byte | input | 8 | Word address value |
| data_vld | input | 1 | Complete data byte received pulse |
| data_byte | input | 8 | Data byte value |
| wp | input | 1 | Write-protect level |
| evt_sup1_low | input | 1 | Supply 1 below threshold |
| evt_sup2_low | input | 1 | Supply 2 below threshold |
| evt_sup3_low | input | 1 | Supply 3 below threshold |
| evt_wdog | input | 1 | Watchdog output active |
| evt_manual | input | 1 | Manual reset active |
| ack_vld | output | 1 | Acknowledge decision valid, one cycle after a byte pulse |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_data | output | 8 | Selected register value |
| cfg_pup | output | 2 | Power-up delay code |
| cfg_wd | output | 2 | Watchdog period code |
| cfg_bp | output | 1 | Block-protect bit |
| nv_busy | output | 1 | Nonvolatile write window active |

## Verification
The bench builds the unit with DEV_SEL set to 1, so a slave byte carrying the default select value of 0 must be refused. This exercises the select comparison rather than leaving it at zero. NV_CYCLES is set to 40, so the whole busy window can be crossed. The bench refuses a slave byte inside that window, waits for busy to fall, and then finishes the unlock replay in a few hundred cycles. REG_ADDR keeps its default of FFh, and a nearby address of FEh is used to confirm that address mismatches are rejected.

// File: rtl/supv_reg_pkg.sv
package supv_reg_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1011;
  localparam int         NUM_FLT  = 5;

  typedef enum logic [2:0] {
    CW_NONE,
    CW_SETWEL,
    CW_SETRWEL,
    CW_NVWR,
    CW_HOLD
  } ctl_op_e;

  // Decide what a configuration data byte would do given the latch state.
  function automatic ctl_op_e ctl_classify(input logic wel, input logic rwel,
                                           input logic [7:0] d);
    ctl_op_e op;
    if (wel && rwel && d[3:1] == 3'b001)      op = CW_NVWR;
    else if (wel && rwel && d[3:1] == 3'b011) op = CW_HOLD;
    else if (d == 8'h02)                      op = CW_SETWEL;
    else if (wel && d == 8'h06)               op = CW_SETRWEL;
    else                                      op = CW_NONE;
    return op;
  endfunction

endpackage

// File: rtl/txn_track.sv
module txn_track
  import supv_reg_pkg::*;
#(
  parameter logic       DEV_SEL  = 1'b0,
  parameter logic [7:0] REG_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txn_start,
  input  logic       txn_stop,
  input  logic       slave_vld,
  input  logic [7:0] slave_byte,
  input  logic       addr_vld,
  input  logic [7:0] addr_byte,
  input  logic       data_vld,
  input  logic [7:0] data_byte,
  input  logic       wp,
  input  logic       busy,
  input  logic       wel,
  input  logic       rwel,
  output logic       ack_vld,
  output logic       ack_ok,
  output logic       rd_sel,
  output logic       cmt_ctrl,
  output logic       cmt_flt,
  output ctl_op_e    cmt_op,
  output logic [4:0] cmt_hi,
  output logic       cmt_b0
);

  logic       sel_ok, is_rd, reg_ctrl, addr_ok;
  logic [1:0] nbytes;
  logic       pend_ok;
  ctl_op_e    pend_op;
  logic [4:0] pend_hi;
  logic       pend_b0;

  logic       slave_hit;
  ctl_op_e    cur_op;
  logic       data_accept;

  always_comb begin
    slave_hit   = (slave_byte[7:4] == DEV_TYPE) && (slave_byte[3] == DEV_SEL) &&
                  !slave_byte[2] && !busy;
    cur_op      = ctl_classify(wel, rwel, data_byte);
    data_accept = sel_ok && !is_rd && addr_ok && (nbytes == 2'd0) && !wp &&
                  (!reg_ctrl || cur_op != CW_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ok   <= 1'b0;
      is_rd    <= 1'b0;
      reg_ctrl <= 1'b0;
      addr_ok  <= 1'b0;
      nbytes   <= 2'd0;
      pend_ok  <= 1'b0;
      pend_op  <= CW_NONE;
      pend_hi  <= '0;
      pend_b0  <= 1'b0;
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
      rd_sel   <= 1'b1;
      cmt_ctrl <= 1'b0;
      cmt_flt  <= 1'b0;
      cmt_op   <= CW_NONE;
      cmt_hi   <= '0;
      cmt_b0   <= 1'b0;
    end else begin
      ack_vld  <= 1'b0;
      ack_ok   <= 1'b0;
      cmt_ctrl <= 1'b0;
      cmt_flt  <= 1'b0;
      if (txn_start) begin
        sel_ok  <= 1'b0;
        addr_ok <= 1'b0;
        nbytes  <= 2'd0;
        pend_ok <= 1'b0;
      end else if (txn_stop) begin
        cmt_ctrl <= pend_ok && reg_ctrl;
        cmt_flt  <= pend_ok && !reg_ctrl;
        cmt_op   <= pend_op;
        cmt_hi   <= pend_hi;
        cmt_b0   <= pend_b0;
        sel_ok   <= 1'b0;
        addr_ok  <= 1'b0;
        nbytes   <= 2'd0;
        pend_ok  <= 1'b0;
      end else if (slave_vld) begin
        ack_vld  <= 1'b1;
        ack_ok   <= slave_hit;
        sel_ok   <= slave_hit;
        is_rd    <= slave_byte[0];
        reg_ctrl <= slave_byte[1];
        addr_ok  <= 1'b0;
        nbytes   <= 2'd0;
        pend_ok  <= 1'b0;
        if (slave_hit) rd_sel <= slave_byte[1];
      end else if (addr_vld) begin
        ack_vld <= 1'b1;
        ack_ok  <= sel_ok && !is_rd;
        addr_ok <= sel_ok && !is_rd && (addr_byte == REG_ADDR);
        nbytes  <= 2'd0;
      end else if (data_vld) begin
        ack_vld <= 1'b1;
        ack_ok  <= data_accept;
        if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
        pend_ok <= data_accept;
        pend_op <= cur_op;
        pend_hi <= data_byte[7:3];
        pend_b0 <= data_byte[0];
      end
    end
  end

  // R8
  second_byte_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (data_vld && !txn_start && !txn_stop && !slave_vld && !addr_vld && nbytes != 2'd0)
      |=> (ack_vld && !ack_ok));

  // R7
  wp_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (data_vld && wp && !txn_start && !txn_stop && !slave_vld && !addr_vld)
      |=> !ack_ok);

  // R1
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(slave_vld || addr_vld || data_vld));

endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import supv_reg_pkg::*;
#(
  parameter int         NV_CYCLES = 500000,
  parameter logic [1:0] PUP_INIT  = 2'b01,
  parameter logic [1:0] WD_INIT   = 2'b11,
  parameter logic       BP_INIT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       commit,
  input  ctl_op_e    op,
  input  logic [3:0] d_hi,
  input  logic       d_b0,
  output logic       wel,
  output logic       rwel,
  output logic [1:0] pup,
  output logic [1:0] wd,
  output logic       bp,
  output logic       busy,
  output logic [7:0] ctrl_byte
);

  localparam int CW = $clog2(NV_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
      pup  <= PUP_INIT;
      wd   <= WD_INIT;
      bp   <= BP_INIT;
      cnt  <= '0;
    end else if (commit) begin
      case (op)
        CW_SETWEL: begin
          wel  <= 1'b1;
          rwel <= 1'b0;
        end
        CW_SETRWEL: begin
          wel  <= 1'b1;
          rwel <= 1'b1;
        end
        CW_NVWR: begin
          pup  <= {d_hi[3], d_b0};
          wd   <= d_hi[2:1];
          bp   <= d_hi[0];
          rwel <= 1'b0;
          cnt  <= CW'(NV_CYCLES);
        end
        default: ;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    busy      = (cnt != '0);
    ctrl_byte = {pup[1], wd, bp, 1'b0, rwel, wel, pup[0]};
  end

  // R4
  rwel_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    rwel |-> wel);

  // R5
  nv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit && op == CW_NVWR) |=> $stable({pup, wd, bp}));

  // R5
  busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit && op == CW_NVWR));

endmodule

// File: rtl/fault_reg.sv
module fault_reg
  import supv_reg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FLT-1:0] evt,
  input  logic               commit,
  input  logic [NUM_FLT-1:0] d,
  output logic [7:0]         flt_byte
);

  localparam int PAD = 8 - NUM_FLT;

  logic [NUM_FLT-1:0] flag;

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (evt[i]) flag[i] <= 1'b0;
      else if (commit) flag[i] <= d[i];
    end

    // R11
    evt_clears_chk: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> !flag[i]);
  end

  assign flt_byte = {flag, {PAD{1'b0}}};

endmodule

// File: rtl/supv_reg_unit.sv
module supv_reg_unit
  import supv_reg_pkg::*;
#(
  parameter logic       DEV_SEL   = 1'b0,
  parameter logic [7:0] REG_ADDR  = 8'hFF,
  parameter int         NV_CYCLES = 500000,
  parameter logic [1:0] PUP_INIT  = 2'b01,
  parameter logic [1:0] WD_INIT   = 2'b11,
  parameter logic       BP_INIT   = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txn_start,
  input  logic       txn_stop,
  input  logic       slave_vld,
  input  logic [7:0] slave_byte,
  input  logic       addr_vld,
  input  logic [7:0] addr_byte,
  input  logic       data_vld,
  input  logic [7:0] data_byte,
  input  logic       wp,
  input  logic       evt_sup1_low,
  input  logic       evt_sup2_low,
  input  logic       evt_sup3_low,
  input  logic       evt_wdog,
  input  logic       evt_manual,
  output logic       ack_vld,
  output logic       ack_ok,
  output logic [7:0] rd_data,
  output logic [1:0] cfg_pup,
  output logic [1:0] cfg_wd,
  output logic       cfg_bp,
  output logic       nv_busy
);

  logic       wel, rwel, rd_sel;
  logic       cmt_ctrl, cmt_flt, cmt_b0;
  ctl_op_e    cmt_op;
  logic [4:0] cmt_hi;
  logic [7:0] ctrl_byte, flt_byte;

  txn_track #(.DEV_SEL(DEV_SEL), .REG_ADDR(REG_ADDR)) u_track (
    .clk(clk), .rst(rst),
    .txn_start(txn_start), .txn_stop(txn_stop),
    .slave_vld(slave_vld), .slave_byte(slave_byte),
    .addr_vld(addr_vld), .addr_byte(addr_byte),
    .data_vld(data_vld), .data_byte(data_byte),
    .wp(wp), .busy(nv_busy), .wel(wel), .rwel(rwel),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .rd_sel(rd_sel),
    .cmt_ctrl(cmt_ctrl), .cmt_flt(cmt_flt), .cmt_op(cmt_op),
    .cmt_hi(cmt_hi), .cmt_b0(cmt_b0)
  );

  ctrl_reg #(
    .NV_CYCLES(NV_CYCLES), .PUP_INIT(PUP_INIT), .WD_INIT(WD_INIT), .BP_INIT(BP_INIT)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .commit(cmt_ctrl), .op(cmt_op), .d_hi(cmt_hi[4:1]), .d_b0(cmt_b0),
    .wel(wel), .rwel(rwel), .pup(cfg_pup), .wd(cfg_wd), .bp(cfg_bp),
    .busy(nv_busy), .ctrl_byte(ctrl_byte)
  );

  fault_reg u_flt (
    .clk(clk), .rst(rst),
    .evt({evt_sup1_low, evt_sup2_low, evt_sup3_low, evt_wdog, evt_manual}),
    .commit(cmt_flt), .d(cmt_hi),
    .flt_byte(flt_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_sel ? ctrl_byte : flt_byte;
  end

  // R10
  busy_slave_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (slave_vld && nv_busy && !txn_start && !txn_stop) |=> !ack_ok);

endmodule

// File: tb/supv_reg_unit_tb_top.sv
module supv_reg_unit_tb_top;

  localparam int NVC = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn_start = 0, txn_stop = 0, slave_vld = 0, addr_vld = 0, data_vld = 0;
  logic [7:0] slave_byte = 0, addr_byte = 0, data_byte = 0;
  logic wp = 0;
  logic evt_sup1_low = 0, evt_sup2_low = 0, evt_sup3_low = 0, evt_wdog = 0, evt_manual = 0;
  logic ack_vld, ack_ok, cfg_bp, nv_busy;
  logic [7:0] rd_data;
  logic [1:0] cfg_pup, cfg_wd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // slave bytes with select bit = 1
  localparam logic [7:0] CW_B = 8'hBA, CR_B = 8'hBB, FW_B = 8'hB8, FR_B = 8'hB9;

  always #10 clk = ~clk;

  supv_reg_unit #(.DEV_SEL(1'b1), .NV_CYCLES(NVC)) dut_i (
    .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
    .slave_vld(slave_vld), .slave_byte(slave_byte),
    .addr_vld(addr_vld), .addr_byte(addr_byte),
    .data_vld(data_vld), .data_byte(data_byte), .wp(wp),
    .evt_sup1_low(evt_sup1_low), .evt_sup2_low(evt_sup2_low),
    .evt_sup3_low(evt_sup3_low), .evt_wdog(evt_wdog), .evt_manual(evt_manual),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .rd_data(rd_data),
    .cfg_pup(cfg_pup), .cfg_wd(cfg_wd), .cfg_bp(cfg_bp), .nv_busy(nv_busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) txn_start = 1;
    @(negedge clk) txn_start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) txn_stop = 1;
    @(negedge clk) txn_stop = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_slave(input logic [7:0] b, output logic ok);
    @(negedge clk) begin slave_byte = b; slave_vld = 1; end
    @(negedge clk) slave_vld = 0;
    ok = ack_vld & ack_ok;
  endtask

  task automatic send_addr(input logic [7:0] b, output logic ok);
    @(negedge clk) begin addr_byte = b; addr_vld = 1; end
    @(negedge clk) addr_vld = 0;
    ok = ack_vld & ack_ok;
  endtask

  task automatic send_data(input logic [7:0] b, output logic ok);
    @(negedge clk) begin data_byte = b; data_vld = 1; end
    @(negedge clk) data_vld = 0;
    ok = ack_vld & ack_ok;
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] sb, input logic [7:0] d,
                        input logic exp_ack);
    logic ok;
    pulse_start();
    send_slave(sb, ok);
    chk({tag, " slave ack"}, ok, 1);
    send_addr(8'hFF, ok);
    chk({tag, " addr ack"}, ok, 1);
    send_data(d, ok);
    chk({tag, " data ack"}, ok, exp_ack);
    pulse_stop();
  endtask

  task automatic rd_reg(input logic [7:0] sb, output logic [7:0] v);
    logic ok;
    pulse_start();
    send_slave(sb, ok);
    @(negedge clk);
    v = rd_data;
    pulse_stop();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R2 rd_data after reset selects config", rd_data, 8'h61);
    chk("R2 pup reset", cfg_pup, 2'b01);
    chk("R2 wd reset", cfg_wd, 2'b11);
    chk("R2 bp reset", cfg_bp, 0);
    chk("R2 busy reset", nv_busy, 0);
    rd_reg(FR_B, v);
    chk("R2 fault reset value", v, 8'h00);
    rd_reg(CR_B, v);
    chk("R12 read select back to config", v, 8'h61);
  endtask

  task automatic t_slave_decode();
    logic ok;
    pulse_start();
    send_slave(8'hB2, ok);
    chk("R1 wrong select bit nack", ok, 0);
    send_addr(8'hFF, ok);
    chk("R1 addr after unmatched slave nack", ok, 0);
    pulse_stop();
    pulse_start();
    send_slave(8'hBE, ok);
    chk("R1 bit2 set nack", ok, 0);
    pulse_stop();
    pulse_start();
    send_slave(8'hAA, ok);
    chk("R1 wrong type nack", ok, 0);
    pulse_stop();
  endtask

  task automatic t_wel_clear();
    logic [7:0] v;
    wr_reg("R7 06h without WEL", CW_B, 8'h06, 0);
    wr_reg("R7 93h without WEL", CW_B, 8'h93, 0);
    rd_reg(CR_B, v);
    chk("R7 config unchanged with WEL clear", v, 8'h61);
  endtask

  task automatic t_wp();
    logic [7:0] v;
    wp = 1;
    wr_reg("R7 wp config", CW_B, 8'h02, 0);
    wr_reg("R7 wp fault", FW_B, 8'hF8, 0);
    wp = 0;
    rd_reg(CR_B, v);
    chk("R7 config unchanged under wp", v, 8'h61);
    rd_reg(FR_B, v);
    chk("R7 fault unchanged under wp", v, 8'h00);
  endtask

  task automatic t_two_bytes();
    logic ok;
    logic [7:0] v;
    pulse_start();
    send_slave(CW_B, ok);
    send_addr(8'hFF, ok);
    send_data(8'h02, ok);
    chk("R8 first byte ack", ok, 1);
    send_data(8'h02, ok);
    chk("R8 second byte nack", ok, 0);
    pulse_stop();
    rd_reg(CR_B, v);
    chk("R8 write abandoned", v, 8'h61);
  endtask

  task automatic t_early_stop();
    logic ok;
    logic [7:0] v;
    pulse_start();
    send_slave(CW_B, ok);
    send_addr(8'hFF, ok);
    pulse_stop();
    rd_reg(CR_B, v);
    chk("R9 stop before data no change", v, 8'h61);
    pulse_start();
    send_slave(CW_B, ok);
    send_addr(8'hFE, ok);
    send_data(8'h02, ok);
    chk("R9 bad address data nack", ok, 0);
    pulse_stop();
    rd_reg(CR_B, v);
    chk("R9 bad address no change", v, 8'h61);
  endtask

  task automatic t_unlock();
    logic ok;
    logic [7:0] v;
    wr_reg("R3 write 02h", CW_B, 8'h02, 1);
    chk("R3 no busy after 02h", nv_busy, 0);
    rd_reg(CR_B, v);
    chk("R3 WEL set", v, 8'h63);
    wr_reg("R4 write 06h", CW_B, 8'h06, 1);
    rd_reg(CR_B, v);
    chk("R4 RWEL set", v, 8'h67);
    wr_reg("R5 write 93h", CW_B, 8'h93, 1);
    chk("R5 busy raised", nv_busy, 1);
    chk("R5 pup loaded", cfg_pup, 2'b11);
    chk("R5 wd loaded", cfg_wd, 2'b00);
    chk("R5 bp loaded", cfg_bp, 1);
    pulse_start();
    send_slave(CR_B, ok);
    chk("R10 slave nack while busy", ok, 0);
    pulse_stop();
    repeat (NVC + 5) @(negedge clk);
    chk("R5 busy dropped", nv_busy, 0);
    rd_reg(CR_B, v);
    chk("R5 RWEL cleared after nv write", v, 8'h93);
  endtask

  task automatic t_hold_pattern();
    logic [7:0] v;
    wr_reg("R6 re-arm 06h", CW_B, 8'h06, 1);
    wr_reg("R6 write 66h", CW_B, 8'h66, 1);
    chk("R6 no busy", nv_busy, 0);
    rd_reg(CR_B, v);
    chk("R6 nv kept and RWEL kept", v, 8'h97);
    wr_reg("R5 write 02h as third step", CW_B, 8'h02, 1);
    repeat (NVC + 5) @(negedge clk);
    rd_reg(CR_B, v);
    chk("R5 nv fields cleared by 02h", v, 8'h02);
  endtask

  task automatic t_faults();
    logic [7:0] v;
    wr_reg("R11 arm faults", FW_B, 8'hFF, 1);
    rd_reg(FR_B, v);
    chk("R11 armed, low bits zero", v, 8'hF8);
    @(negedge clk) evt_sup2_low = 1;
    repeat (2) @(negedge clk);
    evt_sup2_low = 0;
    @(negedge clk) evt_manual = 1;
    repeat (2) @(negedge clk);
    evt_manual = 0;
    rd_reg(FR_B, v);
    chk("R11 supply2 and manual flags cleared", v, 8'hB0);
    evt_wdog = 1;
    wr_reg("R11 write during event", FW_B, 8'hF8, 1);
    evt_wdog = 0;
    rd_reg(FR_B, v);
    chk("R11 event beats write", v, 8'hE8);
    rd_reg(CR_B, v);
    chk("R12 config selected again", v, 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_slave_decode();
    t_wel_clear();
    t_wp();
    t_two_bytes();
    t_early_stop();
    t_unlock();
    t_hold_pattern();
    t_faults();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule